// File: doc/BRIEF.md
# Integer Add/Subtract Status Flag Unit

This block derives the six arithmetic status flags of an integer add or subtract from the two operands and the result that a neighbouring adder produced. It computes carry (borrow for subtraction), signed overflow, sign, zero, a nibble carry out of bit 3 and an even-parity flag over the lowest result byte. Operands may be 8, 16 or 32 bits wide; the narrower sizes sit in the low bits of the 32-bit buses and everything above them is ignored.

The computed flags are captured in a flag register on a clock edge only when the write strobe is high, and a synchronous reset clears them. The register also feeds the carry-in for the chained operations: for add-with-carry and subtract-with-borrow the block presents the stored carry flag on `cin_o`, which the adder adds in (or subtracts) before handing its result back. Because the flags are derived from operands and result, the carry-in is automatically reflected in every flag, including the nibble carry.

Top module: `alu_flag_gen`

## Requirements
- R1: `flags_o` bit 0 is the carry flag; for add (`op_i`=0) and add-with-carry (`op_i`=1) it is set when the unsigned sum of the sized operands and carry-in does not fit the selected size.
- R2: For subtract (`op_i`=2) and subtract-with-borrow (`op_i`=3) bit 0 is set when a borrow occurred, i.e. the unsigned minuend is smaller than subtrahend plus borrow-in.
- R3: `flags_o` bit 5 is set when the signed result does not fit the selected size.
- R4: `flags_o` bit 4 equals the most significant result bit at the selected size.
- R5: `flags_o` bit 3 is set when all result bits within the selected size are zero.
- R6: `flags_o` bit 1 is set when result bits 7..0 hold an even number of ones, for every size.
- R7: `flags_o` bit 2 is set on a carry (add) or borrow (subtract) out of bit 3 into bit 4, with carry-in included.
- R8: `size_i` 0 selects 8 bits, 1 selects 16 bits, 2 and 3 select 32 bits; operand and result bits above the selected size have no effect on any flag.
- R9: `cin_o` equals the stored carry flag when `op_i` is 1 or 3, and 0 when `op_i` is 0 or 2.
- R10: With `we_i` low the flag register keeps its value across a clock edge.
- R11: With `rst` high at a clock edge the flag register becomes all zero, regardless of `we_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 32 | First operand (minuend for subtraction) |
| b_i | input | 32 | Second operand (subtrahend for subtraction) |
| res_i | input | 32 | Result produced by the adder for these operands |
| op_i | input | 2 | 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow |
| size_i | input | 2 | Operand size select |
| we_i | input | 1 | Flag register write strobe |
| cin_o | output | 1 | Carry-in for the adder taken from the stored carry flag |
| flags_o | output | 6 | Stored flags: 5 overflow, 4 sign, 3 zero, 2 nibble carry, 1 parity, 0 carry |

## Verification
Flags are due on `flags_o` one clock edge after the operands are presented with `we_i` high, while `cin_o` reflects the stored carry combinationally in the same cycle the operation code is applied. The driver changes inputs on the falling edge and queues the expected flag word for the next rising edge; the monitor marks that edge and compares a quarter period later, so every comparison lands after exactly one register stage. Hold and reset cycles push their own expectations (previous flags, or zero) through the same queue.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
    localparam int WORD_W   = 32;
    localparam int NIB_W    = 4;
    localparam int PAR_W    = 8;
    localparam int N_SIZES  = 3;
    localparam int FLAG_N   = 6;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_ADC = 2'd1,
        OP_SUB = 2'd2,
        OP_SBB = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;
endpackage

// File: rtl/flag_sizer.sv
module flag_sizer
    import alu_flag_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] r,
    input  size_e             size,
    output logic              top_a,
    output logic              top_b,
    output logic              top_r,
    output logic              all_zero,
    output logic              cy_add,
    output logic              cy_sub
);
    logic [WORD_W-1:0]  gen_add;
    logic [WORD_W-1:0]  gen_sub;
    logic [N_SIZES-1:0] ma_v, mb_v, mr_v, z_v, ca_v, cs_v;

    // carry out of every bit position, recovered from operands and result
    assign gen_add = (a & b) | ((a | b) & ~r);
    assign gen_sub = (~a & b) | ((~a | b) & r);

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int W = 8 << g;
        assign ma_v[g] = a[W-1];
        assign mb_v[g] = b[W-1];
        assign mr_v[g] = r[W-1];
        assign z_v[g]  = ~|r[W-1:0];
        assign ca_v[g] = gen_add[W-1];
        assign cs_v[g] = gen_sub[W-1];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: {top_a, top_b, top_r, all_zero, cy_add, cy_sub} =
                     {ma_v[0], mb_v[0], mr_v[0], z_v[0], ca_v[0], cs_v[0]};
            SZ_HALF: {top_a, top_b, top_r, all_zero, cy_add, cy_sub} =
                     {ma_v[1], mb_v[1], mr_v[1], z_v[1], ca_v[1], cs_v[1]};
            default: {top_a, top_b, top_r, all_zero, cy_add, cy_sub} =
                     {ma_v[2], mb_v[2], mr_v[2], z_v[2], ca_v[2], cs_v[2]};
        endcase
    end
endmodule

// File: rtl/flag_calc.sv
module flag_calc
    import alu_flag_pkg::*;
(
    input  op_e               op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] r,
    input  logic              top_a,
    input  logic              top_b,
    input  logic              top_r,
    input  logic              all_zero,
    input  logic              cy_add,
    input  logic              cy_sub,
    output flags_t            nxt
);
    logic is_sub;

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADC: is_sub = 1'b0;
            OP_SUB, OP_SBB: is_sub = 1'b1;
        endcase
        nxt.cry = is_sub ? cy_sub : cy_add;
        nxt.ovf = is_sub ? ((top_a != top_b) && (top_r != top_a))
                         : ((top_a == top_b) && (top_r != top_a));
        nxt.sgn = top_r;
        nxt.zro = all_zero;
        // carry or borrow into bit 4 shows up as the sum bit disagreeing
        nxt.aux = a[NIB_W] ^ b[NIB_W] ^ r[NIB_W];
        nxt.par = ~^r[PAR_W-1:0];
    end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import alu_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!rst && !we) |=> $stable(q)); // R10
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (q == '0)); // R11
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] res_i,
    input  logic [1:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic              we_i,
    output logic              cin_o,
    output logic [FLAG_N-1:0] flags_o
);
    op_e    op;
    size_e  size;
    logic   top_a, top_b, top_r, all_zero, cy_add, cy_sub;
    flags_t nxt, cur;

    assign op   = op_e'(op_i);
    assign size = size_e'(size_i);

    flag_sizer u_sizer (
        .a(a_i), .b(b_i), .r(res_i), .size(size),
        .top_a(top_a), .top_b(top_b), .top_r(top_r),
        .all_zero(all_zero), .cy_add(cy_add), .cy_sub(cy_sub)
    );

    flag_calc u_calc (
        .op(op), .a(a_i), .b(b_i), .r(res_i),
        .top_a(top_a), .top_b(top_b), .top_r(top_r),
        .all_zero(all_zero), .cy_add(cy_add), .cy_sub(cy_sub),
        .nxt(nxt)
    );

    flag_reg u_reg (
        .clk(clk), .rst(rst), .we(we_i), .d(nxt), .q(cur)
    );

    always_comb begin
        unique case (op)
            OP_ADC, OP_SBB: cin_o = cur.cry;
            OP_ADD, OP_SUB: cin_o = 1'b0;
        endcase
    end

    assign flags_o = cur;

    AST_ZERO_NOT_NEGATIVE: assert property (@(posedge clk) disable iff (rst)
        we_i |=> !(flags_o[3] && flags_o[4])); // R5
    AST_ZERO_HAS_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (!flags_o[3] || flags_o[1])); // R6
endmodule

// File: tb/alu_flag_gen_test.sv
module alu_flag_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_i = '0, b_i = '0, res_i = '0;
    logic [1:0]  op_i = '0, size_i = '0;
    logic        we_i = 1'b0;
    logic        cin_o;
    logic [5:0]  flags_o;

    int tests = 0, fails = 0;
    bit check_vld = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
        bit         is_sub;
    } item_t;
    item_t sb_q[$];

    logic [5:0] model_flags = '0;

    alu_flag_gen uut (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .res_i(res_i),
        .op_i(op_i), .size_i(size_i), .we_i(we_i),
        .cin_o(cin_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: compares one quarter period after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            if (check_vld) begin
                #(CLK_PERIOD/4);
                if (sb_q.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard empty: got %b exp none", flags_o);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    tests++;
                    if (flags_o !== it.exp) begin
                        fails++;
                        $display("FAIL %s: flags got %b exp %b (bit0 %s, bit1 R6, bit2 R7, bit3 R5, bit4 R4, bit5 R3)",
                                 it.tag, flags_o, it.exp, it.is_sub ? "R2" : "R1");
                    end
                end
            end
        end
    end

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] op, input logic [1:0] sz,
                         input bit we, input string tag);
        int          w;
        logic [32:0] m;
        longint      ua, ub, ur, sa, sb, sr, smax, smin;
        logic        cin, sub;
        logic [31:0] res;
        logic [5:0]  e;
        @(negedge clk);
        w   = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m   = (33'd1 << w) - 33'd1;
        sub = op[1];
        cin = op[0] ? model_flags[0] : 1'b0;
        op_i = op;
        #1;
        tests++;
        if (cin_o !== cin) begin
            fails++;
            $display("FAIL R9: cin_o got %b exp %b", cin_o, cin);
        end
        ua = longint'(a & m[31:0]);
        ub = longint'(b & m[31:0]);
        sa = (ua >= (longint'(1) << (w-1))) ? ua - (longint'(1) << w) : ua;
        sb = (ub >= (longint'(1) << (w-1))) ? ub - (longint'(1) << w) : ub;
        smax = (longint'(1) << (w-1)) - 1;
        smin = -(longint'(1) << (w-1));
        if (sub) begin
            ur = ua - ub - longint'(cin);
            sr = sa - sb - longint'(cin);
            e[0] = (ua < ub + longint'(cin));
            e[2] = ((ua & 15) < (ub & 15) + longint'(cin));
        end else begin
            ur = ua + ub + longint'(cin);
            sr = sa + sb + longint'(cin);
            e[0] = (ur > longint'(m));
            e[2] = ((ua & 15) + (ub & 15) + longint'(cin) > 15);
        end
        res  = 32'(ur) & m[31:0];
        e[5] = (sr > smax) || (sr < smin);
        e[4] = res[w-1];
        e[3] = (res == 32'd0);
        e[1] = ~^res[7:0];
        a_i    = a;
        b_i    = b;
        // bits above the size carry junk that must not matter (R8)
        res_i  = res | (~m[31:0] & 32'hA5C3_5A3C);
        size_i = sz;
        we_i   = we;
        if (rst) e = '0;
        else if (!we) e = model_flags;
        model_flags = e;
        sb_q.push_back('{exp: e, tag: tag, is_sub: sub});
        check_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_vld = 1'b0;
        we_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        tests++;
        if (flags_o !== 6'd0) begin
            fails++;
            $display("FAIL R11: reset flags got %b exp 000000", flags_o);
        end
        @(negedge clk);
        rst = 1'b0;

        apply(32'h0000_00FF, 32'h0000_0001, 2'd0, 2'd0, 1, "R1 R5 R7 byte wrap");
        apply(32'h0000_007F, 32'h0000_0001, 2'd0, 2'd0, 1, "R3 R4 byte overflow");
        apply(32'hFFFF_FF80, 32'h1234_5680, 2'd0, 2'd0, 1, "R8 upper bits ignored");
        apply(32'h0000_8000, 32'h0000_0001, 2'd2, 2'd1, 1, "R2 R3 half sub");
        apply(32'h0000_0000, 32'h0000_0001, 2'd2, 2'd2, 1, "R2 R4 word borrow");
        apply(32'h0000_0005, 32'h0000_0005, 2'd3, 2'd2, 1, "R2 R9 sbb with borrow");
        apply(32'hFFFF_FFFF, 32'h0000_0000, 2'd1, 2'd3, 1, "R1 R8 R9 adc wide");
        apply(32'h0000_000F, 32'h0000_0000, 2'd1, 2'd0, 1, "R7 nibble from carry-in");
        apply(32'h0000_0010, 32'h0000_0001, 2'd2, 2'd0, 1, "R7 nibble borrow");
        apply(32'h0000_FFFF, 32'h0000_0001, 2'd0, 2'd1, 1, "R1 R6 half wrap");
        apply(32'h8000_0000, 32'h8000_0000, 2'd0, 2'd2, 1, "R1 R3 R5 word");
        apply(32'h0000_0003, 32'h0000_0004, 2'd2, 2'd0, 1, "R2 R6 byte");
        apply(32'h1111_1111, 32'h2222_2222, 2'd0, 2'd2, 0, "R10 hold");
        apply(32'h0000_0001, 32'h0000_0001, 2'd1, 2'd0, 0, "R9 R10 hold cin");
        for (int i = 0; i < 60; i++) begin
            apply($urandom, $urandom, 2'($urandom), 2'($urandom),
                  ($urandom % 4) != 0, "R1 R2 R3 R4 R5 R6 R7 R8 random");
        end
        rst = 1'b1;
        apply(32'h0000_00FF, 32'h0000_0001, 2'd0, 2'd0, 1, "R11 reset beats write");
        rst = 1'b0;
        apply(32'h0000_0001, 32'h0000_0001, 2'd1, 2'd0, 1, "R9 after reset");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule